// File: doc/BRIEF.md
# SMBus Byte Register Target

This block is the transaction layer of an SMBus target. A bit-level engine in front of it turns the wire activity into single-cycle events: start, repeated start, stop, a received byte, and the end of a transmitted byte. The block decides whether to acknowledge each received byte. It loads the byte the engine must send next. It holds a small file of 8-bit registers that the bus master reaches with the Write Byte and Read Byte transactions.

The block's own 7-bit address has 1 in bit 6 and 0 in bit 5. The lower five bits come from three strap inputs, and each strap can be low, high or floating, which gives 27 possible addresses. The block also takes a broadcast write address, 0x5D, which software can switch off through a register bit. It answers the alert response address, 0x0C, when an alert is pending.

A write changes a register only when the transaction closes with a stop. A write that a repeated start breaks off changes nothing.

Top module: `smb_byte_target`

## Requirements
- R1: Each strap code maps to a trit: 2'b00 is low (0), 2'b01 is high (1), and 2'b10 or 2'b11 is floating (2). The own address is {1'b1, 1'b0, idx[4:0]}, where idx = 9·t2 + 3·t1 + t0. The own address with R/W = 0 is acknowledged.
- R2: Each `ev_byte` gives one `ack_valid` pulse in the next cycle, carrying the decision on `ack`. An address byte that matches nothing is not acknowledged, and every later byte is not acknowledged until the next start or repeated start.
- R3: Address 0x5D with R/W = 0 is acknowledged and used as a write only while bit 0 of register 2 is 1. Reset sets that bit to 1. While the bit is 0, the address is not acknowledged.
- R4: In a Write Byte, the command and data bytes are acknowledged. The register selected by the command takes the data in the cycle after the stop event.
- R5: A repeated start that arrives after the data byte and before the stop discards the write, and every register keeps its value.
- R6: In a Read Byte (own address with write, command, repeated start, own address with read), the read address is acknowledged and `tx_byte` holds the selected register in the same cycle as that acknowledge.
- R7: An own-address read that is not preceded in the same transaction by a command byte and a repeated start is not acknowledged.
- R8: Address 0x0C with R/W = 1 is acknowledged only while `alert_pend` is 1. `tx_byte` then becomes {own address, 1'b0}. `ara_done` pulses in the cycle after the `ev_tx_done` that ends that byte.
- R9: A third byte after the data byte of a write is not acknowledged, and the write is cancelled.
- R10: A command value of NREG or more selects no register. A write to it changes nothing, and a read of it returns 0x00.
- R11: After reset, every register reads 0x00 except register 2, which reads 0x01. `ack_valid`, `ack`, `tx_byte` and `ara_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap0 | input | 2 | Strap code for trit t0 |
| strap1 | input | 2 | Strap code for trit t1 |
| strap2 | input | 2 | Strap code for trit t2 |
| ev_start | input | 1 | Start condition seen |
| ev_rstart | input | 1 | Repeated start seen |
| ev_stop | input | 1 | Stop condition seen |
| ev_byte | input | 1 | A byte has been received |
| rx_byte | input | 8 | Received byte; for an address byte, bit 0 is R/W |
| ev_tx_done | input | 1 | The byte in `tx_byte` has been shifted out |
| alert_pend | input | 1 | An alert is pending |
| ack_valid | output | 1 | Acknowledge decision is valid |
| ack | output | 1 | 1 to acknowledge, 0 to not acknowledge |
| tx_byte | output | 8 | Byte to transmit |
| ara_done | output | 1 | Alert response byte has been sent |
| regs_flat | output | 8*NREG | Register file; register i is at bits [8i+7:8i] |

## Verification
The assertions rely on two things about the bit engine. It raises at most one event per cycle. It raises `ev_tx_done` only after a read that was acknowledged. The stimulus keeps to this: each bench task drives exactly one event for one cycle and then a quiet cycle, and a transmit-done event is issued only after an acknowledged read. Straps and `alert_pend` change only between transactions, so the own address never moves while a byte is being decoded.

// File: rtl/smb_byte_target.sv
module smb_byte_target #(
  parameter int NREG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        strap0,
  input  logic [1:0]        strap1,
  input  logic [1:0]        strap2,
  input  logic              ev_start,
  input  logic              ev_rstart,
  input  logic              ev_stop,
  input  logic              ev_byte,
  input  logic [7:0]        rx_byte,
  input  logic              ev_tx_done,
  input  logic              alert_pend,
  output logic              ack_valid,
  output logic              ack,
  output logic [7:0]        tx_byte,
  output logic              ara_done,
  output logic [8*NREG-1:0] regs_flat
);
  localparam int PTRW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int MWE_REG = 2;
  localparam logic [6:0] MASS_ADDR = 7'h5D;
  localparam logic [6:0] ARA_ADDR = 7'h0C;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_DATA, S_WSTOP, S_TX, S_ARA} st_t;

  st_t        st;
  logic [7:0] rf [NREG];
  logic [7:0] ptr, shadow, rd_byte;
  logic       pend, ptr_ok;
  logic [4:0] idx;
  logic [6:0] own_addr;
  logic       ptr_in, mwe, rw;
  logic [6:0] rx_addr;

  function automatic logic [4:0] trit(input logic [1:0] c);
    return (c == 2'b00) ? 5'd0 : (c == 2'b01) ? 5'd1 : 5'd2;
  endfunction

  always_comb idx = trit(strap2) * 5'd9 + trit(strap1) * 5'd3 + trit(strap0);
  assign own_addr = {2'b10, idx};
  assign ptr_in   = ptr < 8'(NREG);
  assign mwe      = rf[MWE_REG][0];
  assign rw       = rx_byte[0];
  assign rx_addr  = rx_byte[7:1];

  always_comb begin
    rd_byte = 8'h00;
    if (ptr_in) rd_byte = rf[ptr[PTRW-1:0]];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_flat[8*g +: 8] = rf[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ack_valid <= 1'b0;
      ack       <= 1'b0;
      tx_byte   <= 8'h00;
      ara_done  <= 1'b0;
      ptr       <= 8'h00;
      shadow    <= 8'h00;
      pend      <= 1'b0;
      ptr_ok    <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= (i == MWE_REG) ? 8'h01 : 8'h00;
    end else begin
      ack_valid <= 1'b0;
      ara_done  <= 1'b0;
      if (ev_start) begin
        st     <= S_ADDR;
        pend   <= 1'b0;
        ptr_ok <= 1'b0;
      end else if (ev_rstart) begin
        st     <= S_ADDR;
        pend   <= 1'b0;
        ptr_ok <= (st == S_DATA);
      end else if (ev_stop) begin
        if (pend && ptr_in) rf[ptr[PTRW-1:0]] <= shadow;
        pend   <= 1'b0;
        ptr_ok <= 1'b0;
        st     <= S_IDLE;
      end else if (ev_byte) begin
        ack_valid <= 1'b1;
        ack       <= 1'b0;
        case (st)
          S_ADDR: begin
            if (!rw && (rx_addr == own_addr || (rx_addr == MASS_ADDR && mwe))) begin
              ack <= 1'b1;
              st  <= S_CMD;
            end else if (rw && rx_addr == own_addr && ptr_ok) begin
              ack     <= 1'b1;
              tx_byte <= rd_byte;
              st      <= S_TX;
            end else if (rw && rx_addr == ARA_ADDR && alert_pend) begin
              ack     <= 1'b1;
              tx_byte <= {own_addr, 1'b0};
              st      <= S_ARA;
            end else begin
              st <= S_IDLE;
            end
          end
          S_CMD: begin
            ptr <= rx_byte;
            ack <= 1'b1;
            st  <= S_DATA;
          end
          S_DATA: begin
            shadow <= rx_byte;
            pend   <= 1'b1;
            ack    <= 1'b1;
            st     <= S_WSTOP;
          end
          S_WSTOP: begin
            pend <= 1'b0;
            st   <= S_IDLE;
          end
          default: ;
        endcase
      end else if (ev_tx_done) begin
        if (st == S_ARA) ara_done <= 1'b1;
        if (st == S_TX || st == S_ARA) st <= S_IDLE;
      end
    end
  end

  assert_one_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_start, ev_rstart, ev_stop, ev_byte, ev_tx_done}));

  assert_ack_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(ev_byte));

  assert_mass_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_byte && st == S_ADDR && rx_byte == {MASS_ADDR, 1'b0} && !mwe) |=> !ack);

  assert_regs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ev_stop) |-> regs_flat == $past(regs_flat));

  assert_ara_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ara_done |-> $past(ev_tx_done));

  assert_unstrapped_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_byte && st == S_ADDR && rw && rx_addr == own_addr && !ptr_ok) |=> !ack);
endmodule

// File: tb/tb_smb_byte_target.sv
module tb_smb_byte_target;
  localparam int NR = 4;
  logic clk = 0, rst_n = 0;
  logic [1:0] strap0 = 2'b10, strap1 = 2'b01, strap2 = 2'b10;
  logic ev_start = 0, ev_rstart = 0, ev_stop = 0, ev_byte = 0, ev_tx_done = 0, alert_pend = 0;
  logic [7:0] rx_byte = 0;
  logic ack_valid, ack, ara_done;
  logic [7:0] tx_byte;
  logic [8*NR-1:0] regs_flat;

  always #4 clk = ~clk;

  smb_byte_target #(.NREG(NR)) dut (
    .clk(clk), .rst_n(rst_n), .strap0(strap0), .strap1(strap1), .strap2(strap2),
    .ev_start(ev_start), .ev_rstart(ev_rstart), .ev_stop(ev_stop), .ev_byte(ev_byte),
    .rx_byte(rx_byte), .ev_tx_done(ev_tx_done), .alert_pend(alert_pend),
    .ack_valid(ack_valid), .ack(ack), .tx_byte(tx_byte), .ara_done(ara_done),
    .regs_flat(regs_flat));

  int tests = 0, fails = 0;
  bit finished = 0;

  // behavioural reference
  int ph = 0;
  bit m_pend = 0, m_pok = 0, m_av = 0, m_ack = 0, m_done = 0;
  int m_ptr = 0, m_sh = 0;
  logic [7:0] m_tx = 0;
  logic [7:0] m_rf [NR] = '{8'h00, 8'h00, 8'h01, 8'h00};

  function automatic int tv(input logic [1:0] c);
    return (c == 2'b00) ? 0 : (c == 2'b01) ? 1 : 2;
  endfunction
  function automatic int own();
    return 64 + 9 * tv(strap2) + 3 * tv(strap1) + tv(strap0);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model();
    int a;
    bit r;
    a = rx_byte[7:1];
    r = rx_byte[0];
    m_av = 0;
    m_done = 0;
    if (ev_start) begin ph = 1; m_pend = 0; m_pok = 0; end
    else if (ev_rstart) begin m_pok = (ph == 3); ph = 1; m_pend = 0; end
    else if (ev_stop) begin
      if (m_pend && m_ptr < NR) m_rf[m_ptr] = 8'(m_sh);
      m_pend = 0; m_pok = 0; ph = 0;
    end else if (ev_byte) begin
      m_av = 1; m_ack = 0;
      if (ph == 1) begin
        if (!r && (a == own() || (a == 'h5D && m_rf[2][0]))) begin m_ack = 1; ph = 2; end
        else if (r && a == own() && m_pok) begin
          m_ack = 1; ph = 5; m_tx = (m_ptr < NR) ? m_rf[m_ptr] : 8'h00;
        end else if (r && a == 'h0C && alert_pend) begin
          m_ack = 1; ph = 6; m_tx = 8'(own() * 2);
        end else ph = 0;
      end else if (ph == 2) begin m_ptr = rx_byte; m_ack = 1; ph = 3; end
      else if (ph == 3) begin m_sh = rx_byte; m_pend = 1; m_ack = 1; ph = 4; end
      else if (ph == 4) begin m_pend = 0; ph = 0; end
    end else if (ev_tx_done) begin
      if (ph == 6) m_done = 1;
      if (ph == 5 || ph == 6) ph = 0;
    end
  endtask

  task automatic tick();
    logic [8*NR-1:0] mf;
    model();
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NR; i++) mf[8*i +: 8] = m_rf[i];
    chk(ack_valid == m_av, "R2 ack_valid", ack_valid, m_av);
    if (m_av) chk(ack == m_ack, "R2 ack", ack, m_ack);
    chk(tx_byte == m_tx, "R6 tx_byte", tx_byte, m_tx);
    chk(ara_done == m_done, "R8 ara_done", ara_done, m_done);
    chk(regs_flat == mf, "R4 regs", regs_flat, mf);
    ev_start = 0; ev_rstart = 0; ev_stop = 0; ev_byte = 0; ev_tx_done = 0;
  endtask

  task automatic s_start();  ev_start = 1;  tick(); tick(); endtask
  task automatic s_rstart(); ev_rstart = 1; tick(); tick(); endtask
  task automatic s_stop();   ev_stop = 1;   tick(); tick(); endtask
  task automatic s_txdone(); ev_tx_done = 1; tick(); endtask
  task automatic s_byte(input logic [7:0] b); rx_byte = b; ev_byte = 1; tick(); endtask

  function automatic logic [7:0] wa(); return 8'(own() * 2); endfunction
  function automatic logic [7:0] ra(); return 8'(own() * 2 + 1); endfunction

  task automatic wr(input logic [7:0] ad, input logic [7:0] c, input logic [7:0] d);
    s_start(); s_byte(ad); tick(); s_byte(c); tick(); s_byte(d); tick(); s_stop();
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #1;
    chk(ack_valid == 0 && ara_done == 0 && tx_byte == 0, "R11 outputs in reset", {ack_valid, ara_done}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(regs_flat == 32'h0001_0000, "R11 reset regs", regs_flat, 32'h0001_0000);

    // R1 + R4: address 0x57 from straps (2,1,2)
    chk(own() == 'h57, "R1 bench address", own(), 'h57);
    s_start(); s_byte(8'hAE);
    chk(ack_valid && ack, "R1 own write ack", ack, 1);
    tick(); s_byte(8'h01); tick(); s_byte(8'hA5); tick();
    chk(regs_flat[15:8] == 8'h00, "R4 no commit before stop", regs_flat[15:8], 0);
    ev_stop = 1; tick();
    chk(regs_flat[15:8] == 8'hA5, "R4 commit after stop", regs_flat[15:8], 8'hA5);
    tick();

    // R6 read back
    s_start(); s_byte(wa()); tick(); s_byte(8'h01); tick(); s_rstart(); s_byte(ra());
    chk(ack && tx_byte == 8'hA5, "R6 read data", tx_byte, 8'hA5);
    tick(); s_txdone(); tick(); s_stop();

    // R7 read without command
    s_start(); s_byte(ra());
    chk(ack_valid && !ack, "R7 read nacked", ack, 0);
    tick(); s_stop();

    // R2 foreign address, following bytes ignored
    s_start(); s_byte(8'h82);
    chk(!ack, "R2 foreign nack", ack, 0);
    tick(); s_byte(8'h00); tick(); s_byte(8'h33); tick();
    chk(!ack, "R2 later byte nack", ack, 0);
    s_stop();
    chk(regs_flat[7:0] == 0, "R2 regs untouched", regs_flat[7:0], 0);

    // R5 repeated start discards write
    s_start(); s_byte(wa()); tick(); s_byte(8'h00); tick(); s_byte(8'h77); tick();
    s_rstart(); s_stop();
    chk(regs_flat[7:0] == 0, "R5 write discarded", regs_flat[7:0], 0);

    // R3 mass write enabled then disabled
    wr(8'hBA, 8'h03, 8'h3C);
    chk(regs_flat[31:24] == 8'h3C, "R3 mass write", regs_flat[31:24], 8'h3C);
    wr(wa(), 8'h02, 8'h00);
    s_start(); s_byte(8'hBA);
    chk(!ack, "R3 mass masked", ack, 0);
    tick(); s_byte(8'h03); tick(); s_byte(8'h11); tick(); s_stop();
    chk(regs_flat[31:24] == 8'h3C, "R3 reg kept", regs_flat[31:24], 8'h3C);
    wr(wa(), 8'h02, 8'h01);

    // R8 alert response
    s_start(); s_byte(8'h19);
    chk(!ack, "R8 no pending nack", ack, 0);
    tick(); s_stop();
    alert_pend = 1;
    s_start(); s_byte(8'h19);
    chk(ack && tx_byte == 8'hAE, "R8 answer byte", tx_byte, 8'hAE);
    tick(); ev_tx_done = 1; tick();
    chk(ara_done, "R8 done pulse", ara_done, 1);
    tick(); s_stop();
    alert_pend = 0;

    // R9 extra byte cancels write
    s_start(); s_byte(wa()); tick(); s_byte(8'h00); tick(); s_byte(8'h11); tick();
    s_byte(8'h22);
    chk(!ack, "R9 extra nack", ack, 0);
    tick(); s_stop();
    chk(regs_flat[7:0] == 0, "R9 write cancelled", regs_flat[7:0], 0);

    // R10 out-of-range pointer
    wr(wa(), 8'h07, 8'h55);
    s_start(); s_byte(wa()); tick(); s_byte(8'h07); tick(); s_rstart(); s_byte(ra());
    chk(ack && tx_byte == 8'h00, "R10 read zero", tx_byte, 0);
    tick(); s_txdone(); tick(); s_stop();

    // R1 other strap settings
    strap0 = 2'b11; strap1 = 2'b11; strap2 = 2'b11;
    chk(own() == 'h5A, "R1 float code", own(), 'h5A);
    wr(8'hB4, 8'h00, 8'h99);
    chk(regs_flat[7:0] == 8'h99, "R1 addr 0x5A", regs_flat[7:0], 8'h99);
    strap0 = 2'b00; strap1 = 2'b00; strap2 = 2'b00;
    s_start(); s_byte(8'h80);
    chk(ack, "R1 addr 0x40", ack, 1);
    tick(); s_stop();

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule